// File: doc/BRIEF.md
# Prioritized Error Address Capture Register

This block sits beside a flash memory controller and records where a failure happened. Four kinds of failure can be reported, each on its own strobe. Ranked from most to least important they are: ECC double-error detection, read-while-write error, program/erase controller failure, and ECC single-error correction. With each strobe the controller presents the failing address. The block keeps the address of the first failure of the most important class seen so far. It presents that address as a read-only 32-bit value aligned to a 64-bit double word.

An event of a strictly more important class replaces the held address. Events of the same or a less important class leave it alone. Each class also has a sticky status flag, which the controller clears with a per-class clear strobe. Clearing the flag of the class currently held re-arms the register, so the next event of any class is recorded. When an ECC event hits both double words of one page in the same cycle, the controller raises a pairing flag, and the recorded address then has its double-word select bit forced to zero. The program/erase failure input is an active-high failure strobe.

Top module: `err_addr_capture`

## Requirements
- R1: After reset, `cap_o` reads 0 and all four bits of `flag_o` read 0.
- R2: Bits 31..23 and 2..0 of `cap_o` always read 0, and `cap_o[22:3]` holds failing-address bits 22..3 in the same positions.
- R3: When no class is held, an event is recorded. The clock edge that samples the strobe loads `cap_o` with the aligned address, and the new value is visible right after that edge.
- R4: A later event of the class already held leaves `cap_o` unchanged.
- R5: An event of a class less important than the one held leaves `cap_o` unchanged, but it still sets that class's flag.
- R6: An event of a strictly more important class than the one held overwrites `cap_o` with its aligned address.
- R7: Strobe bits are `evt_i[0]` for ECC double error, `evt_i[1]` for read-while-write, `evt_i[2]` for program/erase failure and `evt_i[3]` for ECC single correction, with a lower index meaning more important. When several bits are set in one cycle, only the lowest-index one is recorded.
- R8: If `pair_i` is high and the recorded class is ECC double error or ECC single correction, `cap_o[3]` is 0. For the other two classes, `pair_i` has no effect.
- R9: `flag_o[k]` becomes 1 in the cycle after `evt_i[k]` is high. It stays 1 until a cycle in which `clr_i[k]` is high and `evt_i[k]` is low, and it reads 0 after that cycle.
- R10: In a cycle where the flag of the held class is cleared, or in any later cycle, the next event of any class is recorded as in R3.
- R11: Clearing a flag of a class that is not held does not re-arm the register. Less important events are still ignored afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 4 | Per-class event strobes, bit 0 most important |
| addr_i | input | 32 | Failing byte address that goes with the strobes |
| pair_i | input | 1 | Event hit both double words of one page |
| clr_i | input | 4 | Per-class flag clear strobes |
| flag_o | output | 4 | Sticky per-class status flags |
| cap_o | output | 32 | Captured double-word address |

## Verification
Directed steps walk through the class order: a first capture, then a repeat of the same class, then a more important and a less important class. This separates "first wins" from "most important wins". Multi-bit strobes with the pairing flag show whether the winner is chosen by index and whether bit 3 is forced only for the ECC classes. Clearing a non-held flag and then the held flag shows that only the held class re-arms the register. A long run of sparse random strobes, clears and all-ones addresses, compared against a bench model, covers events that coincide with a clear and checks that the out-of-field bits stay at zero.

// File: rtl/err_cap_pkg.sv
package err_cap_pkg;

   localparam int unsigned NUM_CLS = 4;

   // class index doubles as rank: lower index is more important
   typedef enum logic [1:0] {
      CLS_DED = 2'd0,
      CLS_RWW = 2'd1,
      CLS_PEF = 2'd2,
      CLS_SEC = 2'd3
   } err_cls_e;

   // classes for which a page-pair hit clears the double-word select bit
   localparam logic [NUM_CLS-1:0] PAIR_CLS_MASK =
      (NUM_CLS'(1) << CLS_DED) | (NUM_CLS'(1) << CLS_SEC);

endpackage

// File: rtl/err_prio_enc.sv
module err_prio_enc #(
   parameter int unsigned N  = 4,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   output logic [N-1:0]  grant_o,
   output logic [IW-1:0] idx_o,
   output logic          any_o
);

   logic [N:0] seen;

   assign seen[0] = 1'b0;

   generate
      for (genvar i = 0; i < N; i++) begin : g_chain
         assign grant_o[i]  = req_i[i] & ~seen[i];
         assign seen[i+1]   = seen[i] | req_i[i];
      end
   endgenerate

   assign any_o = seen[N];

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IW'(i);
      end
   end

   // R7
   grant_onehot_chk: assert final ($onehot0(grant_o));

endmodule

// File: rtl/err_addr_align.sv
module err_addr_align #(
   parameter int unsigned REG_W   = 32,
   parameter int unsigned ADDR_HI = 22,
   parameter int unsigned ADDR_LO = 3
) (
   input  logic [REG_W-1:0] addr_i,
   input  logic             pair_clr_i,
   output logic [REG_W-1:0] word_o
);

   localparam int unsigned FW = ADDR_HI - ADDR_LO + 1;
   localparam logic [REG_W-1:0] KEEP  = REG_W'({FW{1'b1}}) << ADDR_LO;
   localparam logic [REG_W-1:0] LOBIT = REG_W'(1) << ADDR_LO;

   generate
      if (ADDR_HI >= REG_W || ADDR_LO > ADDR_HI) begin : g_bad_cfg
         $error("err_addr_align: address field outside register");
      end
   endgenerate

   always_comb begin
      word_o = addr_i & KEEP;
      if (pair_clr_i) word_o = word_o & ~LOBIT;
   end

endmodule

// File: rtl/err_flag_bank.sv
module err_flag_bank #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);

   generate
      for (genvar k = 0; k < N; k++) begin : g_flag
         logic flag_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_q <= 1'b0;
            else if (set_i[k]) flag_q <= 1'b1;
            else if (clr_i[k]) flag_q <= 1'b0;
         end

         assign flag_o[k] = flag_q;

         // R9
         flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> flag_o[k]);

         // R9
         flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_i[k]) |=> !flag_o[k]);
      end
   endgenerate

endmodule

// File: rtl/err_addr_capture.sv
module err_addr_capture
   import err_cap_pkg::*;
#(
   parameter int unsigned REG_W   = 32,
   parameter int unsigned ADDR_HI = 22,
   parameter int unsigned ADDR_LO = 3,
   parameter int unsigned NCLS    = NUM_CLS,
   parameter logic [NCLS-1:0] PAIR_MASK = PAIR_CLS_MASK
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCLS-1:0]  evt_i,
   input  logic [REG_W-1:0] addr_i,
   input  logic             pair_i,
   input  logic [NCLS-1:0]  clr_i,
   output logic [NCLS-1:0]  flag_o,
   output logic [REG_W-1:0] cap_o
);

   localparam int unsigned IW = (NCLS > 1) ? $clog2(NCLS) : 1;
   localparam logic [REG_W-1:0] OUT_MASK =
      ~(REG_W'({(ADDR_HI - ADDR_LO + 1){1'b1}}) << ADDR_LO);

   generate
      if (NCLS < 2) begin : g_bad_ncls
         $error("err_addr_capture: need at least two classes");
      end
      if (ADDR_HI >= REG_W || ADDR_LO > ADDR_HI) begin : g_bad_field
         $error("err_addr_capture: address field outside register");
      end
   endgenerate

   logic [NCLS-1:0]  win_grant;
   logic [IW-1:0]    win_idx;
   logic             win_any;
   logic [REG_W-1:0] aligned;
   logic             pair_clr;

   logic             valid_q;
   logic [IW-1:0]    held_q;
   logic [REG_W-1:0] cap_q;

   logic             held_clr;
   logic             eff_valid;
   logic             take;

   err_prio_enc #(.N(NCLS)) u_enc (
      .req_i   (evt_i),
      .grant_o (win_grant),
      .idx_o   (win_idx),
      .any_o   (win_any)
   );

   assign pair_clr = pair_i & |(win_grant & PAIR_MASK);

   err_addr_align #(
      .REG_W   (REG_W),
      .ADDR_HI (ADDR_HI),
      .ADDR_LO (ADDR_LO)
   ) u_align (
      .addr_i     (addr_i),
      .pair_clr_i (pair_clr),
      .word_o     (aligned)
   );

   err_flag_bank #(.N(NCLS)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt_i),
      .clr_i  (clr_i),
      .flag_o (flag_o)
   );

   // clearing the held class's flag drops the hold in the same cycle
   assign held_clr  = valid_q & clr_i[held_q];
   assign eff_valid = valid_q & ~held_clr;
   assign take      = win_any & (~eff_valid | (win_idx < held_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         held_q  <= '0;
         cap_q   <= '0;
      end else begin
         valid_q <= take | eff_valid;
         if (take) begin
            held_q <= win_idx;
            cap_q  <= aligned;
         end
      end
   end

   assign cap_o = cap_q;

   // R2
   out_field_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_o & OUT_MASK) == '0);

   // R4 R5 R11
   lower_or_same_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !clr_i[held_q] && (!win_any || win_idx >= held_q)) |=> $stable(cap_o));

   // R6 R7
   higher_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && win_any && win_idx < held_q) |=> (cap_o == $past(aligned)));

   // R10
   rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held_clr && win_any) |=> (cap_o == $past(aligned)));

   // R3
   first_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_q && win_any) |=> (valid_q && cap_o == $past(aligned)));

   // R8
   pair_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && pair_i && PAIR_MASK[win_idx]) |=> !cap_o[ADDR_LO]);

endmodule

// File: tb/tb_err_addr_capture.sv
`timescale 1ns/1ps
module tb_err_addr_capture;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  evt_i = '0;
   logic [31:0] addr_i = '0;
   logic        pair_i = 1'b0;
   logic [3:0]  clr_i = '0;
   logic [3:0]  flag_o;
   logic [31:0] cap_o;

   int n_chk = 0;
   int n_fail = 0;

   bit          m_valid = 1'b0;
   int          m_held = 0;
   logic [31:0] m_cap = '0;
   logic [3:0]  m_flag = '0;

   always #4 clk = ~clk;

   err_addr_capture dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_i),
      .addr_i (addr_i),
      .pair_i (pair_i),
      .clr_i  (clr_i),
      .flag_o (flag_o),
      .cap_o  (cap_o)
   );

   function automatic int lowest_bit(input logic [3:0] v);
      for (int i = 0; i < 4; i++) if (v[i]) return i;
      return -1;
   endfunction

   function automatic logic [31:0] align_addr(input logic [31:0] a, input bit force_lo);
      logic [31:0] r;
      r = a & 32'h007F_FFF8;
      if (force_lo) r[3] = 1'b0;
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [3:0] ev, input logic [31:0] ad, input bit pr,
                       input logic [3:0] cl, input string tag);
      int  w;
      bit  ev_valid;
      @(negedge clk);
      evt_i = ev; addr_i = ad; pair_i = pr; clr_i = cl;
      w = lowest_bit(ev);
      ev_valid = m_valid && !cl[m_held];
      if (w >= 0 && (!ev_valid || w < m_held)) begin
         m_cap   = align_addr(ad, pr && (w == 0 || w == 3));
         m_valid = 1'b1;
         m_held  = w;
      end else begin
         m_valid = ev_valid;
      end
      m_flag = (m_flag & ~cl) | ev;
      @(posedge clk);
      #1;
      chk({tag, " cap"}, cap_o, m_cap);
      chk({tag, " flag"}, {28'h0, flag_o}, {28'h0, m_flag});
      chk("R2 out-of-field bits", cap_o & 32'hFF80_0007, 32'h0);
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1
      chk("R1 reset cap", cap_o, 32'h0);
      chk("R1 reset flag", {28'h0, flag_o}, 32'h0);

      step(4'b1000, 32'hFFFF_FFFF, 1'b0, 4'b0000, "R3 first capture");
      step(4'b1000, 32'h0000_1234, 1'b0, 4'b0000, "R4 same class hold");
      step(4'b0100, 32'h0040_0010, 1'b0, 4'b0000, "R6 higher override");
      step(4'b1000, 32'h0000_0088, 1'b0, 4'b0000, "R5 lower ignored");
      step(4'b0011, 32'h0012_3458, 1'b1, 4'b0000, "R7 R8 multi with pair");
      step(4'b0100, 32'h0000_0100, 1'b0, 4'b0010, "R11 non-held clear");
      step(4'b0000, 32'h0000_0000, 1'b0, 4'b0001, "R9 R10 held clear");
      step(4'b1000, 32'h0000_0A08, 1'b1, 4'b0000, "R10 R8 rearmed capture");
      step(4'b0010, 32'h0000_0B08, 1'b1, 4'b0000, "R8 pair ignored on RWW");
      step(4'b0001, 32'h0055_5558, 1'b0, 4'b0010, "R10 clear with event");

      for (int i = 0; i < 3000; i++) begin
         logic [3:0]  ev;
         logic [3:0]  cl;
         logic [31:0] ad;
         ev = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
         cl = ($urandom % 6 == 0) ? 4'(1 << ($urandom % 4)) : 4'h0;
         ad = ($urandom % 8 == 0) ? 32'hFFFF_FFFF : $urandom;
         step(ev, ad, 1'($urandom), cl, "R7 random model");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule